// File: doc/BRIEF.md
# Double-Buffered Burst Serial Port

This block is the host side of a synchronous serial link to a converter-style peripheral. Software writes a transmit word into a holding register. The port moves that word into a shift register, sends it MSB first on a serial data output, and at the same time collects a word from the serial data input into a receive register. The port makes its own data clock, which is a programmable division of the system clock. It also makes its own frame sync, and the receive side runs from that same clock and frame sync. A transmit interrupt pulse marks each holding-to-shift copy. A receive interrupt pulse marks each completed receive word.

A control register holds the settings. It has separate enables for the transmit and receive halves, a word-length select (16 or 8 bits), a frame-mode select (one frame sync per word, or one sync for a run of words) and the data-clock half-period. A word written into the holding register while the previous word is still shifting is sent straight after it, with no idle bit between the two. This allows contiguous streaming at the full rate.

Top module: `burst_serial_port`

## Requirements
- R1: After reset the control register is all zero, the port is halted, and all outputs are low: `sclk`, `fsync`, `sdo_oe`, `tx_irq`, `rx_irq`, and `rx_word` reads 0.
- R2: While transmit-enable (control bit 0) is 1, `sclk` toggles every `half_div+1` system clocks, where `half_div` is control bits 11:8. It starts low.
- R3: When the port is idle, a data write is copied to the shift register on the second rising `sclk` edge after the write. On that same edge `fsync` rises and `tx_irq` pulses for one system clock. `fsync` stays high for exactly one `sclk` period.
- R4: Shifting starts on the first rising `sclk` edge after `fsync` falls. Bits go out MSB first, `sdo` changes only on rising edges, and `sdo_oe` is high while bits are driven.
- R5: `sdi` is sampled on falling `sclk` edges. On the falling edge that follows the last bit of a word, `rx_word` takes the received word and `rx_irq` pulses for one system clock.
- R6: Control bit 2 selects the word length: 0 gives 16 bits and 1 gives 8 bits. In 8-bit mode, data bits 7:0 are sent MSB first, and the received byte is zero-extended in `rx_word`.
- R7: With control bit 3 set to 1 (burst mode), every word gets its own `fsync` pulse. If a new word is written before the last bit is sent, the copy happens on the rising edge of the last bit. The new `fsync` then overlaps that bit, and the next word follows with no gap.
- R8: With control bit 3 set to 0 (continuous mode), `fsync` pulses only for a word that starts from idle. Words that follow back to back get no pulse.
- R9: If no new word has been written, no transfer starts. `sdo_oe` drops on the rising edge that follows the last bit.
- R10: Clearing transmit-enable stops `sclk` low, aborts any frame and forces `fsync` and `sdo_oe` low. While receive-enable (control bit 1) is 0, no `rx_irq` is raised and `rx_word` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_sel | input | 1 | 0 selects the transmit holding register, 1 selects the control register |
| wr_data | input | 16 | CPU write data |
| rx_word | output | 16 | Receive holding register |
| tx_irq | output | 1 | Pulse on each holding-to-shift copy |
| rx_irq | output | 1 | Pulse on each completed receive word |
| sclk | output | 1 | Generated data clock |
| fsync | output | 1 | Generated frame sync |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 means high impedance) |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume that the control register is not rewritten in the middle of a frame, except to clear transmit-enable. They also assume that the word length does not change between a word and the one queued behind it. The bench keeps to this: it changes the control register only while the port is idle, or to disable it. It makes its back-to-back writes right after the transmit interrupt, well ahead of the last bit, and it never writes data on the same clock as a copy. The serial input is a copy of the output with every bit inverted. This makes every received word a known function of the word that was sent.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int DIV_W = 4;

    typedef struct packed {
        logic [DIV_W-1:0] half_div;
        logic             burst;
        logic             short_word;
        logic             rx_run;
        logic             tx_run;
    } port_ctrl_t;

    localparam int CTRL_TX_BIT    = 0;
    localparam int CTRL_RX_BIT    = 1;
    localparam int CTRL_SHORT_BIT = 2;
    localparam int CTRL_BURST_BIT = 3;
    localparam int CTRL_DIV_LSB   = 8;
endpackage

// File: rtl/bsp_clkgen.sv
module bsp_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == half_div);
        if (!run) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk      = st_q.sclk;
    assign rise_tick = run && wrap && !st_q.sclk;
    assign fall_tick = run && wrap &&  st_q.sclk;

    // R2
    clk_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
endmodule

// File: rtl/bsp_tx.sv
module bsp_tx #(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              burst,
    input  logic              short_word,
    input  logic              rise_tick,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              fsync,
    output logic              tx_irq,
    output logic              busy,
    output logic              last_bit,
    output logic              frame_short
);
    localparam int CW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              hold_full;
        logic [1:0]        age;
        logic [WORD_W-1:0] shift;
        logic              short_q;
        logic              start;
        logic              busy;
        logic [CW-1:0]     bits;
        logic              fs;
        logic              sdo;
        logic              oe;
        logic              irq;
    } tx_st_t;

    tx_st_t        st_d, st_q;
    logic [CW-1:0] len_q;
    logic          free_slot;
    logic          copy_idle;
    logic          copy_b2b;

    assign len_q = st_q.short_q ? CW'(SHORT_W) : CW'(WORD_W);

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        free_slot = !st_q.start && (!st_q.busy || st_q.bits == len_q);
        copy_idle = free_slot && st_q.hold_full && (st_q.age != 2'd0);
        copy_b2b  = st_q.busy && !st_q.start && st_q.hold_full &&
                    (st_q.bits == CW'(len_q - 1'b1));
        if (!run) begin
            st_d.start = 1'b0;
            st_d.busy  = 1'b0;
            st_d.bits  = '0;
            st_d.fs    = 1'b0;
            st_d.oe    = 1'b0;
        end else if (rise_tick) begin
            if (st_q.start) begin
                st_d.sdo   = st_q.shift[WORD_W-1];
                st_d.shift = st_q.shift << 1;
                st_d.bits  = CW'(1);
                st_d.busy  = 1'b1;
                st_d.oe    = 1'b1;
            end else if (st_q.busy && st_q.bits != len_q) begin
                st_d.sdo   = st_q.shift[WORD_W-1];
                st_d.shift = st_q.shift << 1;
                st_d.bits  = st_q.bits + 1'b1;
            end else if (st_q.busy) begin
                st_d.busy = 1'b0;
                st_d.oe   = 1'b0;
                st_d.bits = '0;
            end
            st_d.fs    = 1'b0;
            st_d.start = 1'b0;
            if (copy_idle || copy_b2b) begin
                st_d.shift     = short_word ?
                    {st_q.hold[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}} : st_q.hold;
                st_d.short_q   = short_word;
                st_d.start     = 1'b1;
                st_d.fs        = burst || copy_idle;
                st_d.irq       = 1'b1;
                st_d.hold_full = 1'b0;
            end else if (st_q.hold_full && st_q.age != 2'd2) begin
                st_d.age = st_q.age + 1'b1;
            end
        end
        if (wr_en) begin
            st_d.hold      = wr_data;
            st_d.hold_full = 1'b1;
            st_d.age       = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo         = st_q.sdo;
    assign sdo_oe      = st_q.oe;
    assign fsync       = st_q.fs;
    assign tx_irq      = st_q.irq;
    assign busy        = st_q.busy;
    assign last_bit    = st_q.busy && (st_q.bits == len_q);
    assign frame_short = st_q.short_q;

    // R4
    oe_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $fell(fsync));
    // R4
    sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(rise_tick));
endmodule

// File: rtl/bsp_rx.sv
module bsp_rx #(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall_tick,
    input  logic              active,
    input  logic              last_bit,
    input  logic              frame_short,
    input  logic              sdi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_irq
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] word;
        logic              irq;
    } rx_st_t;

    rx_st_t            st_d, st_q;
    logic [WORD_W-1:0] acc_next;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        acc_next = {st_q.acc[WORD_W-2:0], sdi};
        if (run && active && fall_tick) begin
            st_d.acc = acc_next;
            if (last_bit) begin
                st_d.word = frame_short ?
                    {{(WORD_W-SHORT_W){1'b0}}, acc_next[SHORT_W-1:0]} : acc_next;
                st_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word = st_q.word;
    assign rx_irq  = st_q.irq;

    // R10
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(rx_word));
endmodule

// File: rtl/burst_serial_port.sv
module burst_serial_port #(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rx_word,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              sclk,
    output logic              fsync,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);
    import bsp_pkg::*;

    port_ctrl_t ctrl_d, ctrl_q;
    logic       rise_tick, fall_tick;
    logic       busy, last_bit, frame_short;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_sel) begin
            ctrl_d.tx_run     = wr_data[CTRL_TX_BIT];
            ctrl_d.rx_run     = wr_data[CTRL_RX_BIT];
            ctrl_d.short_word = wr_data[CTRL_SHORT_BIT];
            ctrl_d.burst      = wr_data[CTRL_BURST_BIT];
            ctrl_d.half_div   = wr_data[CTRL_DIV_LSB +: DIV_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    bsp_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.tx_run), .half_div(ctrl_q.half_div),
        .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    bsp_tx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.tx_run), .burst(ctrl_q.burst),
        .short_word(ctrl_q.short_word), .rise_tick(rise_tick),
        .wr_en(wr_en && !wr_sel), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .fsync(fsync), .tx_irq(tx_irq),
        .busy(busy), .last_bit(last_bit), .frame_short(frame_short)
    );

    bsp_rx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.tx_run && ctrl_q.rx_run),
        .fall_tick(fall_tick), .active(busy), .last_bit(last_bit),
        .frame_short(frame_short), .sdi(sdi),
        .rx_word(rx_word), .rx_irq(rx_irq)
    );

    // R3
    sync_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> $rose(sclk));
    // R5
    rx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $fell(sclk));
    // R5
    rx_within_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> sdo_oe);
    // R10
    halt_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.tx_run |=> (!sdo_oe && !fsync && !sclk));
endmodule

// File: tb/burst_serial_port_test.sv
module burst_serial_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rx_word;
    logic        tx_irq, rx_irq, sclk, fsync, sdo, sdo_oe, sdi;
    logic        flip = 1'b1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;
    assign sdi = sdo ^ flip;

    burst_serial_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_word(rx_word), .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk(sclk),
        .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    // behavioural reference model
    bit m_run, m_rxrun, m_short, m_burst;
    int m_half, m_cnt;
    bit m_sclk;
    bit h_full;
    int h_val, h_age;
    bit m_start, m_busy, m_fs, m_sdo, m_oe, m_txirq, m_rxirq;
    int m_bits, m_len, m_cur, m_acc, m_rxword;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_rxrun = 0; m_short = 0; m_burst = 0; m_half = 0; m_cnt = 0;
            m_sclk = 0; h_full = 0; h_val = 0; h_age = 0; m_start = 0; m_busy = 0;
            m_fs = 0; m_sdo = 0; m_oe = 0; m_txirq = 0; m_rxirq = 0; m_bits = 0;
            m_len = 16; m_cur = 0; m_acc = 0; m_rxword = 0;
        end else begin
            bit rise, fall, idle_copy, b2b;
            rise = m_run && m_cnt == m_half && !m_sclk;
            fall = m_run && m_cnt == m_half && m_sclk;
            m_txirq = 0;
            m_rxirq = 0;
            if (fall && m_rxrun && m_busy) begin
                m_acc = (m_acc << 1) | int'(sdi);
                if (m_bits == m_len) begin
                    m_rxword = m_acc & ((1 << m_len) - 1);
                    m_rxirq = 1;
                end
            end
            if (!m_run) begin
                m_cnt = 0; m_sclk = 0;
                m_start = 0; m_busy = 0; m_bits = 0; m_fs = 0; m_oe = 0;
            end else begin
                if (m_cnt == m_half) begin m_cnt = 0; m_sclk = !m_sclk; end
                else m_cnt++;
                if (rise) begin
                    idle_copy = !m_start && (!m_busy || m_bits == m_len) && h_full && h_age >= 1;
                    b2b = m_busy && !m_start && h_full && m_bits == m_len - 1;
                    if (m_start) begin
                        m_bits = 1; m_busy = 1; m_oe = 1; m_sdo = m_cur[m_len-1];
                    end else if (m_busy && m_bits < m_len) begin
                        m_sdo = m_cur[m_len-1-m_bits]; m_bits++;
                    end else if (m_busy) begin
                        m_busy = 0; m_oe = 0; m_bits = 0;
                    end
                    m_fs = 0; m_start = 0;
                    if (idle_copy || b2b) begin
                        m_len = m_short ? 8 : 16;
                        m_cur = m_short ? (h_val & 255) : h_val;
                        m_start = 1; m_fs = m_burst || idle_copy; m_txirq = 1; h_full = 0;
                    end else if (h_full && h_age < 2) h_age++;
                end
            end
            if (wr_en && wr_sel) begin
                m_run = wr_data[0]; m_rxrun = wr_data[1]; m_short = wr_data[2];
                m_burst = wr_data[3]; m_half = int'(wr_data[11:8]);
            end else if (wr_en) begin
                h_val = int'(wr_data); h_full = 1; h_age = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison and event counters
    int fs_rises, oe_falls, txirq_n, rxirq_n, sclk_rises;
    logic p_fs, p_oe, p_sclk;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sclk == m_sclk, "R2", "sclk", sclk, m_sclk);
            chk(fsync == m_fs, "R3", "fsync", fsync, m_fs);
            chk(tx_irq == m_txirq, "R3", "tx_irq", tx_irq, m_txirq);
            chk(sdo_oe == m_oe, "R9", "sdo_oe", sdo_oe, m_oe);
            if (m_oe) chk(sdo == m_sdo, "R4", "sdo", sdo, m_sdo);
            chk(rx_irq == m_rxirq, "R5", "rx_irq", rx_irq, m_rxirq);
            chk(int'(rx_word) == m_rxword, "R5", "rx_word", rx_word, m_rxword);
            if (fsync && !p_fs) fs_rises++;
            if (!sdo_oe && p_oe) oe_falls++;
            if (sclk && !p_sclk) sclk_rises++;
            if (tx_irq) txirq_n++;
            if (rx_irq) rxirq_n++;
        end
        p_fs = fsync; p_oe = sdo_oe; p_sclk = sclk;
    end

    task automatic clr();
        fs_rises = 0; oe_falls = 0; txirq_n = 0; rxirq_n = 0; sclk_rises = 0;
    endtask

    task automatic wr(input bit sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tx();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tx_irq) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr();
        p_fs = 0; p_oe = 0; p_sclk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and halted port
        @(negedge clk);
        chk(!sclk && !fsync && !sdo_oe, "R1", "pins after reset",
            {sclk, fsync, sdo_oe}, 0);
        chk(!tx_irq && !rx_irq && rx_word == 0, "R1", "irq/rx after reset",
            {tx_irq, rx_irq, rx_word}, 0);
        idle(20);
        chk(sclk_rises == 0, "R1", "clock idle after reset", sclk_rises, 0);

        // R7 burst single word, R9 no further transfer
        wr(1, 16'h010B);
        clr();
        wr(0, 16'hA5C3);
        idle(300);
        chk(rx_word == 16'h5A3C, "R5", "burst rx word", rx_word, 16'h5A3C);
        chk(fs_rises == 1, "R7", "one sync per word", fs_rises, 1);
        chk(txirq_n == 1 && rxirq_n == 1, "R9", "single transfer only",
            txirq_n * 16 + rxirq_n, 17);
        chk(!sdo_oe && oe_falls == 1, "R9", "output released", oe_falls, 1);

        // R7 back-to-back burst, no gap
        wr(1, 16'h000B);
        clr();
        wr(0, 16'h1234);
        wait_tx();
        wr(0, 16'hFEDC);
        idle(300);
        chk(fs_rises == 2, "R7", "sync per b2b word", fs_rises, 2);
        chk(oe_falls == 1, "R7", "no gap between words", oe_falls, 1);
        chk(rx_word == 16'h0123, "R7", "second word rx", rx_word, 16'h0123);

        // R6 short word
        wr(1, 16'h030F);
        clr();
        wr(0, 16'h12F0);
        idle(400);
        chk(rx_word == 16'h000F, "R6", "8-bit rx word", rx_word, 16'h000F);
        chk(txirq_n == 1 && rxirq_n == 1, "R6", "8-bit single transfer",
            txirq_n * 16 + rxirq_n, 17);

        // R8 continuous mode
        wr(1, 16'h0003);
        clr();
        wr(0, 16'h0F0F);
        wait_tx();
        wr(0, 16'h3C3C);
        idle(300);
        chk(fs_rises == 1, "R8", "one sync for run", fs_rises, 1);
        chk(txirq_n == 2 && rxirq_n == 2, "R8", "two words sent",
            txirq_n * 16 + rxirq_n, 34);
        chk(rx_word == 16'hC3C3, "R8", "continuous rx", rx_word, 16'hC3C3);

        // R10 abort mid-frame
        wr(1, 16'h010B);
        wr(0, 16'hFFFF);
        idle(30);
        wr(1, 16'h0000);
        clr();
        idle(100);
        chk(sclk_rises == 0 && !sclk, "R10", "clock stopped", sclk_rises, 0);
        chk(!sdo_oe && !fsync && rxirq_n == 0, "R10", "frame aborted",
            {sdo_oe, fsync, 8'(rxirq_n)}, 0);

        // R10 receive disabled
        begin
            logic [15:0] keep;
            keep = rx_word;
            wr(1, 16'h0009);
            clr();
            wr(0, 16'h5555);
            idle(300);
            chk(rxirq_n == 0 && rx_word == keep, "R10", "rx held while disabled",
                rx_word, keep);
            chk(txirq_n == 1, "R10", "tx still runs", txirq_n, 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule